// File: doc/BRIEF.md
# Vsync-Synchronised Shadow Register Bank

This block holds the programmable settings of a two-window display path as pairs of registers. A simple address/data port writes the front copy of each register and reads it back. The live copy is what the display pipeline sees, and it changes only on a vsync pulse. Software can therefore rewrite several related fields of a window, such as its address, size, position and format, and have them all take effect on the same frame.

Software arms a transfer by writing the update-request bit. At the next vsync, the global timing words are copied from front to live. Each window is copied too, unless its protect bit is set. A protected window keeps its arming until the protect bit is cleared, and it then latches at the first vsync after the clear. The window enable sits in the window's control word, so a window starts or stops only at a frame boundary. A software-reset bit puts every register back to its defaults straight away. A per-window dirty output shows which windows hold written values that have not yet reached the live copy.

Top module: `vsync_shadow_regs`

## Requirements
- R1: A write to a window word (address = window*8 + index, addresses 0..15) or a timing word (addresses 16..19) updates the front copy. The front copy reads back on `bus_rdata_o` at that address from the next cycle.
- R2: At a vsync, a window that is armed (an update was requested since it last latched) and not protected copies all its front words to `win_live_o`. Word w*8+r of `win_live_o` occupies bits [(w*8+r)*32 +: 32]. The copied values are the front values from before that clock edge.
- R3: A window whose protect bit is set at a vsync keeps its live copy and stays armed. After the protect bit is cleared, the next vsync latches that window without a new update request.
- R4: At a vsync with an update pending, the timing words are copied to `tim_live_o` whatever the protect bits are.
- R5: Writing 1 to bit 0 of the control word (address 20) requests an update. Bit 0 reads back 1 until the vsync that serves it, and 0 after it. Writing 0 to bit 0 does not cancel a pending request.
- R6: A vsync with no update pending, or a clock with no vsync, leaves every live copy unchanged.
- R7: `win_en_o[w]` is bit 0 of live word 7 of window w. Writing that bit therefore starts or stops the window only at the vsync that latches it.
- R8: `win_dirty_o[w]` is set by any write to window w and cleared when window w latches. A write in the same cycle as the latch keeps it set, and the live copy then takes the value the front copy held before that write.
- R9: Writing 1 to bit 1 of the control word clears all front and live words, the protect bits, the arming, the update request and the dirty flags at the next edge. The other bits of that write have no effect.
- R10: Protect bits sit at control bits 8+w. They take effect on the write and read back at those positions.
- R11: Addresses 21 and above read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 5 | Word address for write and readback |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Front-copy readback of `bus_addr_i` (combinational) |
| vsync_i | input | 1 | One-cycle frame-boundary pulse |
| win_live_o | output | 512 | Live words of all windows, flattened |
| win_en_o | output | 2 | Live enable bit of each window |
| win_dirty_o | output | 2 | Window holds unlatched writes |
| tim_live_o | output | 128 | Live timing words, flattened |

## Verification
Every registered result appears one clock edge after its stimulus. Writes, vsync latches, the update bit clearing, dirty flags and software reset all follow that rule, while readback is combinational on the address. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares every output at the following falling edge, so each check lands exactly one edge after the cause. The directed sequences apply vsync, protect and update in separate cycles and also in the same cycle. This pins down the ordering rules: the old front value latches, and a write made in the latch cycle keeps its window dirty.

// File: rtl/shadow_regs_pkg.sv
package shadow_regs_pkg;
   // control word bit positions
   localparam int CTRL_UPD_BIT  = 0;
   localparam int CTRL_RST_BIT  = 1;
   localparam int CTRL_PROT_LSB = 8;
   // enable bit inside the last word of each window
   localparam int WIN_EN_BIT    = 0;
endpackage

// File: rtl/shadow_win_slot.sv
module shadow_win_slot #(
   parameter int DATA_W   = 32,
   parameter int WIN_REGS = 8,
   localparam int IDX_W   = $clog2(WIN_REGS)
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         srst_i,
   input  logic                         vsync_i,
   input  logic                         arm_i,
   input  logic                         protect_i,
   input  logic                         wr_i,
   input  logic [IDX_W-1:0]             wr_idx_i,
   input  logic [DATA_W-1:0]            wdata_i,
   output logic [WIN_REGS*DATA_W-1:0]   front_o,
   output logic [WIN_REGS*DATA_W-1:0]   live_o,
   output logic                         dirty_o
);
   logic [WIN_REGS-1:0][DATA_W-1:0] front_q, live_q;
   logic armed_q, dirty_q, latch;

   assign latch = vsync_i & armed_q & ~protect_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         front_q <= '0;
         live_q  <= '0;
         armed_q <= 1'b0;
         dirty_q <= 1'b0;
      end else if (srst_i) begin
         front_q <= '0;
         live_q  <= '0;
         armed_q <= 1'b0;
         dirty_q <= 1'b0;
      end else begin
         if (latch) live_q <= front_q;
         if (wr_i) front_q[wr_idx_i] <= wdata_i;
         if (arm_i) armed_q <= 1'b1;
         else if (latch) armed_q <= 1'b0;
         if (wr_i) dirty_q <= 1'b1;
         else if (latch) dirty_q <= 1'b0;
      end
   end

   assign front_o = front_q;
   assign live_o  = live_q;
   assign dirty_o = dirty_q;

   p_latch_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch && !srst_i) |=> (live_q == $past(front_q)));
   p_protect_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vsync_i && protect_i && !srst_i) |=> $stable(live_q));
   p_quiet_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!vsync_i && !srst_i) |=> $stable(live_q));
   p_dirty_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch && !wr_i && !srst_i) |=> !dirty_q);
   p_dirty_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !srst_i) |=> dirty_q);
endmodule

// File: rtl/shadow_tim_bank.sv
module shadow_tim_bank #(
   parameter int DATA_W   = 32,
   parameter int TIM_REGS = 4,
   localparam int TIDX_W  = (TIM_REGS > 1) ? $clog2(TIM_REGS) : 1
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       srst_i,
   input  logic                       latch_i,
   input  logic                       wr_i,
   input  logic [TIDX_W-1:0]          wr_idx_i,
   input  logic [DATA_W-1:0]          wdata_i,
   output logic [TIM_REGS*DATA_W-1:0] front_o,
   output logic [TIM_REGS*DATA_W-1:0] live_o
);
   logic [TIM_REGS-1:0][DATA_W-1:0] front_q, live_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         front_q <= '0;
         live_q  <= '0;
      end else if (srst_i) begin
         front_q <= '0;
         live_q  <= '0;
      end else begin
         if (latch_i) live_q <= front_q;
         if (wr_i) front_q[wr_idx_i] <= wdata_i;
      end
   end

   assign front_o = front_q;
   assign live_o  = live_q;

   p_tim_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch_i && !srst_i) |=> (live_q == $past(front_q)));
   p_tim_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!latch_i && !srst_i) |=> $stable(live_q));
endmodule

// File: rtl/shadow_ctrl.sv
module shadow_ctrl #(
   parameter int NUM_WIN = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               vsync_i,
   input  logic               wr_i,
   input  logic               upd_bit_i,
   input  logic               rst_bit_i,
   input  logic [NUM_WIN-1:0] prot_bits_i,
   output logic               srst_o,
   output logic               arm_o,
   output logic               upd_o,
   output logic [NUM_WIN-1:0] prot_o
);
   logic               upd_q;
   logic [NUM_WIN-1:0] prot_q;

   assign srst_o = wr_i & rst_bit_i;
   assign arm_o  = wr_i & upd_bit_i & ~rst_bit_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         upd_q  <= 1'b0;
         prot_q <= '0;
      end else if (srst_o) begin
         upd_q  <= 1'b0;
         prot_q <= '0;
      end else begin
         if (arm_o) upd_q <= 1'b1;
         else if (vsync_i) upd_q <= 1'b0;
         if (wr_i) prot_q <= prot_bits_i;
      end
   end

   assign upd_o  = upd_q;
   assign prot_o = prot_q;

   p_upd_served_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vsync_i && !arm_o) |=> !upd_q);
   p_upd_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_q && !vsync_i && !srst_o) |=> upd_q);
   p_prot_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(prot_q));
   p_srst_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_o |=> (!upd_q && prot_q == '0));
endmodule

// File: rtl/vsync_shadow_regs.sv
module vsync_shadow_regs
   import shadow_regs_pkg::*;
#(
   parameter int NUM_WIN  = 2,
   parameter int WIN_REGS = 8,
   parameter int TIM_REGS = 4,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5
) (
   input  logic                                clk_i,
   input  logic                                rst_ni,
   input  logic                                bus_wr_i,
   input  logic [ADDR_W-1:0]                   bus_addr_i,
   input  logic [DATA_W-1:0]                   bus_wdata_i,
   output logic [DATA_W-1:0]                   bus_rdata_o,
   input  logic                                vsync_i,
   output logic [NUM_WIN*WIN_REGS*DATA_W-1:0]  win_live_o,
   output logic [NUM_WIN-1:0]                  win_en_o,
   output logic [NUM_WIN-1:0]                  win_dirty_o,
   output logic [TIM_REGS*DATA_W-1:0]          tim_live_o
);
   localparam int IDX_W     = $clog2(WIN_REGS);
   localparam int WSEL_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
   localparam int TIDX_W    = (TIM_REGS > 1) ? $clog2(TIM_REGS) : 1;
   localparam int WIN_SPAN  = NUM_WIN * WIN_REGS;
   localparam int CTRL_ADDR = WIN_SPAN + TIM_REGS;
   localparam logic [ADDR_W-1:0] TIM_A  = ADDR_W'(WIN_SPAN);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   // elaboration-time parameter checks
   if (WIN_REGS < 2 || (WIN_REGS & (WIN_REGS - 1)) != 0) begin : g_bad_win_regs
      $error("WIN_REGS must be a power of two, at least 2");
   end
   if (NUM_WIN < 1 || NUM_WIN > DATA_W - CTRL_PROT_LSB) begin : g_bad_num_win
      $error("NUM_WIN out of range for the control word");
   end
   if (ADDR_W < $clog2(CTRL_ADDR + 1)) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_WIN-1:0][WIN_REGS-1:0][DATA_W-1:0] win_front, win_live;
   logic [TIM_REGS-1:0][DATA_W-1:0]              tim_front;
   logic                win_hit, tim_hit, ctrl_hit;
   logic [WSEL_W-1:0]   win_sel;
   logic [IDX_W-1:0]    win_idx;
   logic [TIDX_W-1:0]   tim_idx;
   logic                srst, arm, upd;
   logic [NUM_WIN-1:0]  prot;

   assign win_hit  = bus_wr_i && (bus_addr_i < TIM_A);
   assign tim_hit  = bus_wr_i && (bus_addr_i >= TIM_A) && (bus_addr_i < CTRL_A);
   assign ctrl_hit = bus_wr_i && (bus_addr_i == CTRL_A);
   assign win_idx  = bus_addr_i[IDX_W-1:0];
   assign win_sel  = WSEL_W'(bus_addr_i >> IDX_W);
   assign tim_idx  = TIDX_W'(bus_addr_i - TIM_A);

   shadow_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .vsync_i     (vsync_i),
      .wr_i        (ctrl_hit),
      .upd_bit_i   (bus_wdata_i[CTRL_UPD_BIT]),
      .rst_bit_i   (bus_wdata_i[CTRL_RST_BIT]),
      .prot_bits_i (bus_wdata_i[CTRL_PROT_LSB +: NUM_WIN]),
      .srst_o      (srst),
      .arm_o       (arm),
      .upd_o       (upd),
      .prot_o      (prot)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      shadow_win_slot #(.DATA_W(DATA_W), .WIN_REGS(WIN_REGS)) u_slot (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .srst_i    (srst),
         .vsync_i   (vsync_i),
         .arm_i     (arm),
         .protect_i (prot[w]),
         .wr_i      (win_hit && (win_sel == WSEL_W'(w))),
         .wr_idx_i  (win_idx),
         .wdata_i   (bus_wdata_i),
         .front_o   (win_front[w]),
         .live_o    (win_live[w]),
         .dirty_o   (win_dirty_o[w])
      );
      assign win_en_o[w] = win_live[w][WIN_REGS-1][WIN_EN_BIT];
   end

   shadow_tim_bank #(.DATA_W(DATA_W), .TIM_REGS(TIM_REGS)) u_tim (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .srst_i   (srst),
      .latch_i  (vsync_i & upd),
      .wr_i     (tim_hit),
      .wr_idx_i (tim_idx),
      .wdata_i  (bus_wdata_i),
      .front_o  (tim_front),
      .live_o   (tim_live_o)
   );

   assign win_live_o = win_live;

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i < TIM_A) begin
         bus_rdata_o = win_front[win_sel][win_idx];
      end else if (bus_addr_i < CTRL_A) begin
         bus_rdata_o = tim_front[tim_idx];
      end else if (bus_addr_i == CTRL_A) begin
         bus_rdata_o[CTRL_UPD_BIT] = upd;
         bus_rdata_o[CTRL_PROT_LSB +: NUM_WIN] = prot;
      end
   end

   p_en_frame_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!vsync_i && !srst) |=> $stable(win_en_o));
   p_srst_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst |=> (win_live_o == '0 && tim_live_o == '0 && win_dirty_o == '0));
endmodule

// File: tb/vsync_shadow_regs_tb_top.sv
`timescale 1ns/1ps
module vsync_shadow_regs_tb_top;
   localparam int NW = 2, WR = 8, TR = 4, DW = 32, AW = 5;
   localparam int TIMA = 16, CTRLA = 20;

   logic clk = 1'b0, rst_ni = 1'b0;
   logic bus_wr_i = 1'b0, vsync_i = 1'b0;
   logic [AW-1:0] bus_addr_i = '0;
   logic [DW-1:0] bus_wdata_i = '0, bus_rdata_o;
   logic [NW*WR*DW-1:0] win_live_o;
   logic [NW-1:0] win_en_o, win_dirty_o;
   logic [TR*DW-1:0] tim_live_o;

   int n_checks = 0, n_fails = 0;

   always #2 clk = ~clk;

   vsync_shadow_regs dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
      .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .vsync_i(vsync_i),
      .win_live_o(win_live_o), .win_en_o(win_en_o), .win_dirty_o(win_dirty_o),
      .tim_live_o(tim_live_o)
   );

   // reference model, built from the requirements
   logic [DW-1:0] m_front [NW][WR];
   logic [DW-1:0] m_live  [NW][WR];
   logic [DW-1:0] m_tfront[TR];
   logic [DW-1:0] m_tlive [TR];
   bit m_upd;
   bit m_arm[NW], m_prot[NW], m_dirty[NW];

   task automatic chk(string tag, logic [511:0] got, logic [511:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic model_clear();
      for (int w = 0; w < NW; w++) begin
         for (int r = 0; r < WR; r++) begin m_front[w][r] = '0; m_live[w][r] = '0; end
         m_arm[w] = 0; m_prot[w] = 0; m_dirty[w] = 0;
      end
      for (int t = 0; t < TR; t++) begin m_tfront[t] = '0; m_tlive[t] = '0; end
      m_upd = 0;
   endtask

   task automatic model_step(bit wr, int a, logic [DW-1:0] d, bit vs);
      bit lat;
      if (wr && a == CTRLA && d[1]) begin
         model_clear();   // R9
         return;
      end
      for (int w = 0; w < NW; w++) begin
         lat = vs && m_arm[w] && !m_prot[w];
         if (lat) begin
            for (int r = 0; r < WR; r++) m_live[w][r] = m_front[w][r];
            m_arm[w] = 0; m_dirty[w] = 0;
         end
      end
      if (vs && m_upd) begin
         for (int t = 0; t < TR; t++) m_tlive[t] = m_tfront[t];
         m_upd = 0;
      end
      if (wr) begin
         if (a < TIMA) begin
            m_front[a / WR][a % WR] = d; m_dirty[a / WR] = 1;
         end else if (a < CTRLA) begin
            m_tfront[a - TIMA] = d;
         end else if (a == CTRLA) begin
            for (int w = 0; w < NW; w++) m_prot[w] = d[8 + w];
            if (d[0]) begin
               m_upd = 1;
               for (int w = 0; w < NW; w++) m_arm[w] = 1;
            end
         end
      end
   endtask

   function automatic logic [DW-1:0] exp_read(int a);
      logic [DW-1:0] v = '0;
      if (a < TIMA) v = m_front[a / WR][a % WR];
      else if (a < CTRLA) v = m_tfront[a - TIMA];
      else if (a == CTRLA) begin
         v[0] = m_upd;
         for (int w = 0; w < NW; w++) v[8 + w] = m_prot[w];
      end
      return v;
   endfunction

   function automatic logic [NW*WR*DW-1:0] exp_live();
      logic [NW*WR*DW-1:0] v;
      for (int w = 0; w < NW; w++)
         for (int r = 0; r < WR; r++) v[(w*WR + r)*DW +: DW] = m_live[w][r];
      return v;
   endfunction

   function automatic logic [TR*DW-1:0] exp_tim();
      logic [TR*DW-1:0] v;
      for (int t = 0; t < TR; t++) v[t*DW +: DW] = m_tlive[t];
      return v;
   endfunction

   function automatic logic [NW-1:0] exp_en();
      logic [NW-1:0] v;
      for (int w = 0; w < NW; w++) v[w] = m_live[w][WR-1][0];
      return v;
   endfunction

   function automatic logic [NW-1:0] exp_dirty();
      logic [NW-1:0] v;
      for (int w = 0; w < NW; w++) v[w] = m_dirty[w];
      return v;
   endfunction

   task automatic compare_all();
      chk("R1 readback", bus_rdata_o, exp_read(int'(bus_addr_i)));
      chk("R2 window live", win_live_o, exp_live());
      chk("R4 timing live", tim_live_o, exp_tim());
      chk("R7 enable", win_en_o, exp_en());
      chk("R8 dirty", win_dirty_o, exp_dirty());
   endtask

   // one cycle: drive at falling edge, model at rising edge, compare at next falling edge
   task automatic cyc(bit wr, int a, logic [DW-1:0] d, bit vs);
      bus_wr_i = wr; bus_addr_i = AW'(a); bus_wdata_i = d; vsync_i = vs;
      @(posedge clk);
      model_step(wr, a, d, vs);
      @(negedge clk);
      bus_wr_i = 1'b0; vsync_i = 1'b0;
      compare_all();
   endtask

   function automatic logic [DW-1:0] live_word(int w, int r);
      return win_live_o[(w*WR + r)*DW +: DW];
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_ni = 1'b1;
      compare_all();   // R9 reset state

      // R1, R6: write a window word, vsync with nothing pending
      cyc(1, 3, 32'hCAFE_0003, 0);
      cyc(0, 3, 0, 0);
      chk("R1 front readback", bus_rdata_o, 32'hCAFE_0003);
      cyc(0, 3, 0, 1);
      chk("R6 no request keeps live", live_word(0, 3), 32'h0);

      // R10, R3, R4: protect window 1, request update, vsync
      cyc(1, 8, 32'hA5A5_0001, 0);
      cyc(1, TIMA, 32'h0000_1234, 0);
      cyc(1, CTRLA, 32'h0000_0201, 0);
      chk("R10 protect readback", bus_rdata_o, 32'h0000_0201);
      chk("R5 pending reads one", bus_rdata_o[0], 1'b1);
      cyc(0, CTRLA, 0, 1);
      chk("R3 protected window holds", live_word(1, 0), 32'h0);
      chk("R2 unprotected window latched", live_word(0, 3), 32'hCAFE_0003);
      chk("R4 timing latched despite protect", tim_live_o[DW-1:0], 32'h0000_1234);
      chk("R5 served request reads zero", bus_rdata_o[0], 1'b0);
      cyc(1, CTRLA, 32'h0, 0);
      chk("R3 still protected dirty", win_dirty_o[1], 1'b1);
      cyc(0, 0, 0, 1);
      chk("R3 latch after protect clear", live_word(1, 0), 32'hA5A5_0001);
      chk("R8 dirty cleared on latch", win_dirty_o[1], 1'b0);

      // R7: enable takes effect only at vsync
      cyc(1, WR-1, 32'h1, 0);
      cyc(1, CTRLA, 32'h1, 0);
      chk("R7 enable waits for vsync", win_en_o[0], 1'b0);
      cyc(0, 0, 0, 1);
      chk("R7 enable after vsync", win_en_o[0], 1'b1);

      // R5: writing zero does not cancel
      cyc(1, CTRLA, 32'h1, 0);
      cyc(1, CTRLA, 32'h0, 0);
      chk("R5 zero write keeps pending", bus_rdata_o[0], 1'b1);

      // R8: write in the latch cycle
      cyc(1, 1, 32'h0000_BEEF, 1);
      chk("R8 latch takes old front", live_word(0, 1), 32'h0);
      chk("R8 write in latch keeps dirty", win_dirty_o[0], 1'b1);

      // R11: unmapped address
      cyc(1, 25, 32'hFFFF_FFFF, 0);
      chk("R11 unmapped reads zero", bus_rdata_o, 32'h0);

      // R9: software reset with other bits set
      cyc(1, CTRLA, 32'h0000_0303, 0);
      chk("R9 reset clears control", bus_rdata_o, 32'h0);
      chk("R9 reset clears live", win_live_o, '0);
      chk("R9 reset clears dirty", win_dirty_o, '0);

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         int a;
         logic [DW-1:0] d;
         bit wr, vs;
         wr = ($urandom % 2) == 0;
         vs = ($urandom % 8) == 0;
         case ($urandom % 10)
            0, 1:    a = CTRLA;
            2:       a = 21 + ($urandom % 11);
            3:       a = TIMA + ($urandom % TR);
            default: a = $urandom % (NW * WR);
         endcase
         d = $urandom;
         if (a == CTRLA) begin
            d[1] = ($urandom % 24) == 0;
            d[0] = ($urandom % 2) == 0;
         end
         cyc(wr, a, d, vs);
      end

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end
endmodule